// File: doc/BRIEF.md
# Pipeline forwarding and hazard unit

This unit is the purely combinational hazard logic of a five-stage in-order pipeline with fetch, decode/register-read, ALU, memory and write-back stages. Each cycle it looks at the two source register numbers of the instruction sitting in decode. It sets them against the final write destinations of the three older instructions in the ALU, memory and write-back stages. For each operand it tells the datapath where the freshest value lives: the register file, or the result held in one of the three later stages.

A destination is not simply a field of the instruction word. Each stage supplies its Rt and Rd fields along with a 2-bit destination select, and the unit resolves that select to Rd, Rt, the link register 31 or the auxiliary register 27 before any compare. A load in the ALU stage has no result that decode can use yet. When decode reads the load's destination, the unit requests a one-cycle stall: the front end holds and a bubble goes into the ALU stage. A redirect from a branch or jump kills the two younger instructions. If a redirect arrives in the same cycle as a stall, the redirect overrides the stall.

Top module: `hz_unit`

## Requirements
- R1: The destination used in every compare comes from that stage's 2-bit select: 0 selects the Rd field, 1 selects the Rt field, 2 selects register 31 and 3 selects register 27.
- R2: Each of the two operands (decode Rs and decode Rt) gets its own 2-bit bypass select, worked out independently: 0 = register file, 1 = ALU-stage result, 2 = memory-stage result, 3 = write-back value.
- R3: If more than one stage matches an operand, the ALU stage wins over the memory stage, and the memory stage wins over write-back.
- R4: A stage whose write enable is low never matches, neither for bypass nor for stall detection.
- R5: Register 0 never matches. An operand that names register 0 always selects 0, and a destination of 0 never raises a stall.
- R6: `load_use_o` is 1 exactly when the ALU-stage instruction is a load with write enable set and a nonzero resolved destination, and that destination equals decode Rs or decode Rt.
- R7: When no redirect is present, a load-use hazard drives `hold_o` to 1 and `kill_alu_o` to 1, and `kill_dec_o` stays 0.
- R8: When `redirect_i` is 1, `kill_dec_o` and `kill_alu_o` are both 1 and `hold_o` is 0, whatever the load-use state.
- R9: A match against a non-load instruction in the ALU stage selects the ALU bypass (1). In that case `load_use_o`, `hold_o` and `kill_alu_o` all stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dec_rs_i | input | 5 | First source register of the decode-stage instruction |
| dec_rt_i | input | 5 | Second source register of the decode-stage instruction |
| alu_rt_i | input | 5 | Rt field of the ALU-stage instruction |
| alu_rd_i | input | 5 | Rd field of the ALU-stage instruction |
| alu_wsel_i | input | 2 | Destination select of the ALU-stage instruction |
| alu_we_i | input | 1 | ALU-stage instruction writes a register |
| alu_load_i | input | 1 | ALU-stage instruction is a load |
| mem_rt_i | input | 5 | Rt field of the memory-stage instruction |
| mem_rd_i | input | 5 | Rd field of the memory-stage instruction |
| mem_wsel_i | input | 2 | Destination select of the memory-stage instruction |
| mem_we_i | input | 1 | Memory-stage instruction writes a register |
| wb_rt_i | input | 5 | Rt field of the write-back-stage instruction |
| wb_rd_i | input | 5 | Rd field of the write-back-stage instruction |
| wb_wsel_i | input | 2 | Destination select of the write-back-stage instruction |
| wb_we_i | input | 1 | Write-back-stage instruction writes a register |
| redirect_i | input | 1 | A branch or jump is redirecting fetch this cycle |
| fwd_rs_sel_o | output | 2 | Bypass select for the Rs operand |
| fwd_rt_sel_o | output | 2 | Bypass select for the Rt operand |
| load_use_o | output | 1 | Load-use hazard detected |
| hold_o | output | 1 | Hold the PC and the fetch-to-decode register |
| kill_dec_o | output | 1 | Turn the instruction entering decode into a no-op |
| kill_alu_o | output | 1 | Write a bubble (write enable cleared) into the ALU stage |

## Verification
The hardest case to reach is a collision between stages: the same nonzero register is named in two or three stages at once, each with a different destination select, and with only some write enables set. This is what exposes a wrong priority or a compare made on the raw Rd field. Pure random register numbers almost never line up this way. The random stimulus therefore draws every register number from a pool of four values that includes 0, 27 and 31, so selects 2 and 3 collide with real fields quite often. Directed vectors add triple matches, a load-use hazard that coincides with a redirect, and loads whose destination is register 0.

// File: rtl/hz_pkg.sv
// Shared constants and encodings for the pipeline hazard unit.
// Assumes a 32-entry register file with register 0 hard-wired to zero.
package hz_pkg;
    localparam int REG_W    = 5;
    localparam int NSTG     = 3;   // ALU, memory, write-back, in priority order
    localparam int NOPER    = 2;   // decode Rs, decode Rt
    localparam int LINK_REG = (1 << REG_W) - 1;
    localparam int AUX_REG  = 27;

    typedef enum logic [1:0] {
        BYP_RF  = 2'd0,
        BYP_ALU = 2'd1,
        BYP_MEM = 2'd2,
        BYP_WB  = 2'd3
    } byp_e;

    typedef enum logic [1:0] {
        DST_RD   = 2'd0,
        DST_RT   = 2'd1,
        DST_LINK = 2'd2,
        DST_AUX  = 2'd3
    } dst_e;
endpackage

// File: rtl/hz_dest_sel.sv
// Resolves one stage's final write destination from its select and fields.
// Flags the destination as live only if the stage writes a register other
// than register 0. Assumes the select encoding given by hz_pkg::dst_e.
module hz_dest_sel #(
    parameter int REG_W    = hz_pkg::REG_W,
    parameter int LINK_REG = hz_pkg::LINK_REG,
    parameter int AUX_REG  = hz_pkg::AUX_REG
) (
    input  logic [REG_W-1:0] rt_i,
    input  logic [REG_W-1:0] rd_i,
    input  logic [1:0]       wsel_i,
    input  logic             we_i,
    output logic [REG_W-1:0] dst_o,
    output logic             live_o
);
    import hz_pkg::*;

    // Pick the destination register named by the select.
    always_comb begin
        unique case (dst_e'(wsel_i))
            DST_RD:   dst_o = rd_i;
            DST_RT:   dst_o = rt_i;
            DST_LINK: dst_o = REG_W'(LINK_REG);
            default:  dst_o = REG_W'(AUX_REG);
        endcase
    end

    // A destination counts only when written and nonzero.
    always_comb live_o = we_i && (dst_o != '0);
endmodule

// File: rtl/hz_bypass_pick.sv
// Chooses the bypass source for one decode operand.
// Stage index 0 has the highest priority. Select value i+1 names stage i,
// and 0 names the register file. Assumes NSTG <= 3 so the select fits 2 bits.
module hz_bypass_pick #(
    parameter int REG_W = hz_pkg::REG_W,
    parameter int NSTG  = hz_pkg::NSTG
) (
    input  logic [REG_W-1:0]      src_i,
    input  logic [NSTG*REG_W-1:0] dst_i,
    input  logic [NSTG-1:0]       live_i,
    output logic [1:0]            sel_o
);
    // Scan from lowest to highest priority so the youngest match is last.
    always_comb begin
        sel_o = 2'd0;
        for (int i = NSTG - 1; i >= 0; i--) begin
            if (live_i[i] && (dst_i[i*REG_W +: REG_W] == src_i) && (src_i != '0))
                sel_o = 2'(i + 1);
        end
    end
endmodule

// File: rtl/hz_load_use.sv
// Detects a load in the ALU stage whose destination is read in decode.
// Assumes live_i already excludes unwritten and register-0 destinations.
// Both source fields are compared, whether or not the instruction uses them.
module hz_load_use #(
    parameter int REG_W = hz_pkg::REG_W
) (
    input  logic [REG_W-1:0] alu_dst_i,
    input  logic             alu_live_i,
    input  logic             alu_load_i,
    input  logic [REG_W-1:0] rs_i,
    input  logic [REG_W-1:0] rt_i,
    output logic             hit_o
);
    // Raise the hazard when either source reads the pending load result.
    always_comb hit_o = alu_live_i && alu_load_i &&
                        ((alu_dst_i == rs_i) || (alu_dst_i == rt_i));
endmodule

// File: rtl/hz_unit.sv
// Top of the forwarding and hazard unit for a five-stage pipeline. Purely
// combinational. Assumes the redirect is raised by the instruction in the
// ALU stage, so the two younger instructions (fetch and decode) are killed.
// A redirect overrides a same-cycle load-use stall.
module hz_unit #(
    parameter int REG_W = hz_pkg::REG_W
) (
    input  logic [REG_W-1:0] dec_rs_i,
    input  logic [REG_W-1:0] dec_rt_i,
    input  logic [REG_W-1:0] alu_rt_i,
    input  logic [REG_W-1:0] alu_rd_i,
    input  logic [1:0]       alu_wsel_i,
    input  logic             alu_we_i,
    input  logic             alu_load_i,
    input  logic [REG_W-1:0] mem_rt_i,
    input  logic [REG_W-1:0] mem_rd_i,
    input  logic [1:0]       mem_wsel_i,
    input  logic             mem_we_i,
    input  logic [REG_W-1:0] wb_rt_i,
    input  logic [REG_W-1:0] wb_rd_i,
    input  logic [1:0]       wb_wsel_i,
    input  logic             wb_we_i,
    input  logic             redirect_i,
    output logic [1:0]       fwd_rs_sel_o,
    output logic [1:0]       fwd_rt_sel_o,
    output logic             load_use_o,
    output logic             hold_o,
    output logic             kill_dec_o,
    output logic             kill_alu_o
);
    localparam int NSTG  = hz_pkg::NSTG;
    localparam int NOPER = hz_pkg::NOPER;

    logic [NSTG*REG_W-1:0]  stg_rt, stg_rd, stg_dst;
    logic [NSTG*2-1:0]      stg_wsel;
    logic [NSTG-1:0]        stg_we, stg_live;
    logic [NOPER*REG_W-1:0] opr_src;
    logic [NOPER*2-1:0]     opr_sel;

    // Gather the per-stage fields in priority order: ALU, memory, write-back.
    always_comb begin
        stg_rt   = {wb_rt_i,   mem_rt_i,   alu_rt_i};
        stg_rd   = {wb_rd_i,   mem_rd_i,   alu_rd_i};
        stg_wsel = {wb_wsel_i, mem_wsel_i, alu_wsel_i};
        stg_we   = {wb_we_i,   mem_we_i,   alu_we_i};
        opr_src  = {dec_rt_i,  dec_rs_i};
    end

    for (genvar s = 0; s < NSTG; s++) begin : g_stage
        hz_dest_sel #(.REG_W(REG_W)) u_dest (
            .rt_i   (stg_rt[s*REG_W +: REG_W]),
            .rd_i   (stg_rd[s*REG_W +: REG_W]),
            .wsel_i (stg_wsel[s*2 +: 2]),
            .we_i   (stg_we[s]),
            .dst_o  (stg_dst[s*REG_W +: REG_W]),
            .live_o (stg_live[s])
        );
    end

    for (genvar o = 0; o < NOPER; o++) begin : g_oper
        hz_bypass_pick #(.REG_W(REG_W), .NSTG(NSTG)) u_pick (
            .src_i  (opr_src[o*REG_W +: REG_W]),
            .dst_i  (stg_dst),
            .live_i (stg_live),
            .sel_o  (opr_sel[o*2 +: 2])
        );
    end

    hz_load_use #(.REG_W(REG_W)) u_lu (
        .alu_dst_i  (stg_dst[0 +: REG_W]),
        .alu_live_i (stg_live[0]),
        .alu_load_i (alu_load_i),
        .rs_i       (dec_rs_i),
        .rt_i       (dec_rt_i),
        .hit_o      (load_use_o)
    );

    // Combine the stall and the redirect into the pipeline control outputs.
    always_comb begin
        fwd_rs_sel_o = opr_sel[0 +: 2];
        fwd_rt_sel_o = opr_sel[2 +: 2];
        hold_o       = load_use_o && !redirect_i;
        kill_dec_o   = redirect_i;
        kill_alu_o   = redirect_i || load_use_o;
    end
endmodule

// File: rtl/hz_unit_chk.sv
// Assertion checker for hz_unit, attached by bind. The unit is
// combinational, so the checks are immediate assertions on settled values.
module hz_unit_chk #(
    parameter int REG_W = hz_pkg::REG_W
) (
    input logic [REG_W-1:0] dec_rs_i,
    input logic [REG_W-1:0] dec_rt_i,
    input logic             alu_we_i,
    input logic             alu_load_i,
    input logic             mem_we_i,
    input logic             wb_we_i,
    input logic             redirect_i,
    input logic [1:0]       fwd_rs_sel_o,
    input logic [1:0]       fwd_rt_sel_o,
    input logic             load_use_o,
    input logic             hold_o,
    input logic             kill_dec_o,
    input logic             kill_alu_o
);
    // Check the relations between inputs and outputs whenever they change.
    always_comb begin
        p_zero_rs_r5: assert (dec_rs_i != '0 || fwd_rs_sel_o == 2'd0)
            else $error("register 0 forwarded on Rs");
        p_zero_rt_r5: assert (dec_rt_i != '0 || fwd_rt_sel_o == 2'd0)
            else $error("register 0 forwarded on Rt");
        p_alu_we_r4: assert (!((fwd_rs_sel_o == 2'd1 || fwd_rt_sel_o == 2'd1) && !alu_we_i))
            else $error("ALU bypass without write enable");
        p_mem_we_r4: assert (!((fwd_rs_sel_o == 2'd2 || fwd_rt_sel_o == 2'd2) && !mem_we_i))
            else $error("memory bypass without write enable");
        p_wb_we_r4: assert (!((fwd_rs_sel_o == 2'd3 || fwd_rt_sel_o == 2'd3) && !wb_we_i))
            else $error("write-back bypass without write enable");
        p_lu_load_r6: assert (!load_use_o || (alu_we_i && alu_load_i))
            else $error("load-use without a writing load");
        p_hold_kill_r7: assert (!hold_o || kill_alu_o)
            else $error("hold without ALU bubble");
        p_redirect_r8: assert (!redirect_i || (kill_dec_o && kill_alu_o && !hold_o))
            else $error("redirect did not flush or still holds");
    end
endmodule

bind hz_unit hz_unit_chk #(.REG_W(REG_W)) u_chk (.*);

// File: tb/hz_unit_bench.sv
// Self-checking bench for hz_unit: directed corner cases, then random
// vectors from a narrow register pool, all against a reference model.
module hz_unit_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic [4:0] dec_rs, dec_rt, alu_rt, alu_rd, mem_rt, mem_rd, wb_rt, wb_rd;
    logic [1:0] alu_ws, mem_ws, wb_ws;
    logic       alu_we, alu_ld, mem_we, wb_we, redir;
    logic [1:0] fwd_rs, fwd_rt;
    logic       lu, hold, kdec, kalu;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    hz_unit u_hz_unit (
        .dec_rs_i(dec_rs), .dec_rt_i(dec_rt),
        .alu_rt_i(alu_rt), .alu_rd_i(alu_rd), .alu_wsel_i(alu_ws),
        .alu_we_i(alu_we), .alu_load_i(alu_ld),
        .mem_rt_i(mem_rt), .mem_rd_i(mem_rd), .mem_wsel_i(mem_ws), .mem_we_i(mem_we),
        .wb_rt_i(wb_rt), .wb_rd_i(wb_rd), .wb_wsel_i(wb_ws), .wb_we_i(wb_we),
        .redirect_i(redir),
        .fwd_rs_sel_o(fwd_rs), .fwd_rt_sel_o(fwd_rt), .load_use_o(lu),
        .hold_o(hold), .kill_dec_o(kdec), .kill_alu_o(kalu)
    );

    // R1 reference: 0 Rd, 1 Rt, 2 reg 31, 3 reg 27
    function automatic logic [4:0] ref_dst(logic [4:0] rt, logic [4:0] rd, logic [1:0] ws);
        case (ws)
            2'd0: return rd;
            2'd1: return rt;
            2'd2: return 5'd31;
            default: return 5'd27;
        endcase
    endfunction

    // R2..R5 reference: priority ALU, memory, write-back; reg 0 never matches
    function automatic logic [1:0] ref_sel(logic [4:0] src,
                                           logic [4:0] d0, logic w0,
                                           logic [4:0] d1, logic w1,
                                           logic [4:0] d2, logic w2);
        if (src == 5'd0) return 2'd0;
        if (w0 && d0 == src) return 2'd1;
        if (w1 && d1 == src) return 2'd2;
        if (w2 && d2 == src) return 2'd3;
        return 2'd0;
    endfunction

    task automatic check(string tag, string what, int got, int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, got, exp);
        end
    endtask

    // Wait for settled outputs away from the edge and compare all of them.
    task automatic verify(string tag);
        logic [4:0] da, dm, dw;
        logic       elu;
        @(negedge clk);
        #1;
        da = ref_dst(alu_rt, alu_rd, alu_ws);
        dm = ref_dst(mem_rt, mem_rd, mem_ws);
        dw = ref_dst(wb_rt, wb_rd, wb_ws);
        elu = alu_we && alu_ld && (da != 5'd0) && (da == dec_rs || da == dec_rt);
        check(tag, "fwd_rs", fwd_rs, ref_sel(dec_rs, da, alu_we, dm, mem_we, dw, wb_we));
        check(tag, "fwd_rt", fwd_rt, ref_sel(dec_rt, da, alu_we, dm, mem_we, dw, wb_we));
        check(tag, "load_use", lu, elu);
        check(tag, "hold", hold, elu && !redir);
        check(tag, "kill_dec", kdec, redir);
        check(tag, "kill_alu", kalu, elu || redir);
    endtask

    task automatic clear();
        {dec_rs, dec_rt, alu_rt, alu_rd, mem_rt, mem_rd, wb_rt, wb_rd} = '0;
        {alu_ws, mem_ws, wb_ws} = '0;
        {alu_we, alu_ld, mem_we, wb_we, redir} = '0;
    endtask

    function automatic logic [4:0] pick_reg();
        case ($urandom % 4)
            0: return 5'd0;
            1: return 5'd27;
            2: return 5'd31;
            default: return 5'd5;
        endcase
    endfunction

    initial begin
        void'($urandom(32'd1234));
        clear();
        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        // Idle state: all-zero inputs give all-zero outputs
        verify("R2");
        check("R2", "idle fwd_rs", fwd_rs, 0);
        check("R7", "idle hold", hold, 0);

        // R1: each destination select against a distinct register
        clear(); alu_we = 1; alu_rd = 5'd9; alu_rt = 5'd10; alu_ws = 2'd0; dec_rs = 5'd9;
        verify("R1"); check("R1", "sel Rd", fwd_rs, 1);
        alu_ws = 2'd1; dec_rs = 5'd10; verify("R1"); check("R1", "sel Rt", fwd_rs, 1);
        alu_ws = 2'd2; dec_rs = 5'd31; verify("R1"); check("R1", "sel link", fwd_rs, 1);
        alu_ws = 2'd3; dec_rs = 5'd27; verify("R1"); check("R1", "sel aux", fwd_rs, 1);
        dec_rs = 5'd9; verify("R1"); check("R1", "raw Rd ignored", fwd_rs, 0);

        // R3: all three stages name the same register
        clear(); dec_rs = 5'd7; dec_rt = 5'd7;
        alu_we = 1; alu_rd = 5'd7; mem_we = 1; mem_rd = 5'd7; wb_we = 1; wb_rd = 5'd7;
        verify("R3"); check("R3", "triple", fwd_rs, 1);
        alu_we = 0; verify("R3"); check("R3", "mem over wb", fwd_rt, 2);
        mem_we = 0; verify("R3"); check("R3", "wb only", fwd_rt, 3);

        // R4: matching destination with write enable low
        wb_we = 0; verify("R4"); check("R4", "no we", fwd_rs, 0);
        alu_we = 0; alu_ld = 1; verify("R4"); check("R4", "load no we", lu, 0);

        // R2: independent operands from different stages
        clear(); dec_rs = 5'd3; dec_rt = 5'd4;
        mem_we = 1; mem_rt = 5'd3; mem_ws = 2'd1; wb_we = 1; wb_rd = 5'd4;
        verify("R2"); check("R2", "rs mem", fwd_rs, 2); check("R2", "rt wb", fwd_rt, 3);

        // R5: register 0 as source and as load destination
        clear(); alu_we = 1; alu_ld = 1; alu_rd = 5'd0; mem_we = 1; wb_we = 1;
        verify("R5"); check("R5", "zero src", fwd_rs, 0); check("R5", "zero stall", lu, 0);

        // R6/R7: load-use on the Rt operand
        clear(); alu_we = 1; alu_ld = 1; alu_rt = 5'd12; alu_ws = 2'd1; dec_rt = 5'd12;
        verify("R6"); check("R6", "load_use", lu, 1);
        check("R7", "hold", hold, 1); check("R7", "kill_dec", kdec, 0);

        // R8: redirect in the same cycle as a load-use stall
        redir = 1; verify("R8");
        check("R8", "hold", hold, 0); check("R8", "kill_dec", kdec, 1); check("R8", "kill_alu", kalu, 1);

        // R9: non-load ALU producer forwards without stall
        clear(); alu_we = 1; alu_rd = 5'd20; dec_rs = 5'd20;
        verify("R9"); check("R9", "fwd", fwd_rs, 1); check("R9", "no stall", kalu, 0);

        // Random vectors from a colliding register pool
        for (int n = 0; n < 3000; n++) begin
            dec_rs = pick_reg(); dec_rt = pick_reg();
            alu_rt = pick_reg(); alu_rd = pick_reg(); alu_ws = 2'($urandom);
            mem_rt = pick_reg(); mem_rd = pick_reg(); mem_ws = 2'($urandom);
            wb_rt = pick_reg(); wb_rd = pick_reg(); wb_ws = 2'($urandom);
            alu_we = 1'($urandom); alu_ld = 1'($urandom);
            mem_we = 1'($urandom); wb_we = 1'($urandom);
            redir = (($urandom % 5) == 0);
            verify("R3");
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: ends a hung run as a failed check
    initial begin
        #(500_000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule